// File: doc/BRIEF.md
# Trigger Latency Buffer and Derandomizer

The block keeps every bunch-crossing data word for a fixed number of clock cycles in a ring of storage. Each cycle it writes the incoming word at the write pointer and presents the word at the read pointer. The distance between the two pointers is the trigger latency. When a first-level accept strobe arrives, the word leaving the ring in that cycle is copied into a derandomizing FIFO. The readout side empties that FIFO at its own pace through a show-ahead read port.

Both ring pointer start values and the usable FIFO depth are configuration inputs. They are captured only while reset is held. Once reset is released, changing them has no effect until the next reset. An accept that finds the FIFO at its configured depth is dropped, and a sticky overflow flag records the loss.

Top module: `latency_derand`

## Requirements
- R1: While `rstN` is low and in the cycle after its release, `empty` is 1, `full` is 0 and `overflow` is 0. The FIFO is emptied, and `rdInit`, `wrInit` and `depthSel` are captured on every clock edge that has `rstN` low.
- R2: On every clock edge after reset, the ring stores `dataIn`. An accept on a given edge pushes the `dataIn` word that was presented L edges earlier. L = (`wrInit` - `rdInit`) mod 256, and L = 0 means 256.
- R3: An accept on an edge where `full` is 1 is dropped and sets `overflow`. `overflow` then stays 1 until the next reset.
- R4: `depthSel` codes 0, 1, 2 and 3 select a usable depth of 16, 32, 64 and 128 words. `full` is 1 exactly when the number of stored words equals the selected depth.
- R5: Words leave the FIFO in the order they were accepted. While `empty` is 0, `rdData` shows the oldest stored word, and a `popReq` on an edge removes it.
- R6: A `popReq` while `empty` is 1 is ignored: the FIFO stays empty and no word is lost or duplicated.
- R7: An accept and a pop on the same edge, with `full` 0 and `empty` 0, leave the stored word count unchanged and keep the order.
- R8: Changes to `rdInit`, `wrInit` or `depthSel` after reset release do not alter the latency or the depth.
- R9: `empty` is 1 exactly when the FIFO holds no words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rstN | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| dataIn | input | 54 | Data word for the current crossing |
| accept | input | 1 | First-level accept strobe |
| popReq | input | 1 | Readout request to remove the oldest FIFO word |
| rdInit | input | 8 | Ring read pointer start value |
| wrInit | input | 8 | Ring write pointer start value |
| depthSel | input | 2 | Usable FIFO depth code (0:16, 1:32, 2:64, 3:128) |
| rdData | output | 54 | Oldest FIFO word (show-ahead) |
| empty | output | 1 | FIFO holds no words |
| full | output | 1 | FIFO holds the selected depth |
| overflow | output | 1 | Sticky flag for a dropped accept |

## Verification
The hardest case to reach is an accept that lands on the same edge as a pop while the FIFO sits exactly at its configured depth. The accept must be dropped even though a slot frees up in that same cycle.

The stimulus gets there by filling a 16-word FIFO with consecutive accepts and then raising accept and pop together. It then checks that `full` falls, that `overflow` rises and that the next word shown is the second one accepted.

The wrapped latency cases are reached by choosing start pointers whose difference crosses the 255-to-0 boundary, or equals zero. Every word the bench pushes is a distinct function of its crossing index, so a latency that is off by one cycle shows up as a data mismatch.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic load;   // restart pointers from configuration
    logic push;   // copy the ring output into the FIFO
    logic pop;    // retire the oldest FIFO word
  } lbd_strobe_t;
endpackage

// File: rtl/lbd_control.sv
module lbd_control
  import lbd_pkg::*;
#(
  parameter int FIFO_AW = 7,
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accept,
  input  logic             popReq,
  input  logic [SEL_W-1:0] depthSel,
  output lbd_strobe_t      strobes,
  output logic             empty,
  output logic             full,
  output logic             overflow
);
  localparam int CNT_W     = FIFO_AW + 1;
  localparam int FIFO_MAX  = 1 << FIFO_AW;
  localparam int NUM_SIZES = 1 << SEL_W;

  logic [CNT_W-1:0] sizeTable [NUM_SIZES];
  logic [CNT_W-1:0] depthDecoded;
  logic [CNT_W-1:0] depthReg;
  logic [CNT_W-1:0] count;
  logic             pushOk;
  logic             popOk;

  // Each selectable size is the physical depth halved per code step below the top
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    assign sizeTable[g] = CNT_W'(FIFO_MAX >> (NUM_SIZES - 1 - g));
  end

  assign depthDecoded = sizeTable[depthSel];

  assign full   = (count == depthReg);
  assign empty  = (count == '0);
  assign pushOk = accept & ~full;
  assign popOk  = popReq & ~empty;

  always_comb begin
    strobes.load = ~rstN;
    strobes.push = pushOk & rstN;
    strobes.pop  = popOk & rstN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthReg <= depthDecoded;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
      if (accept && full) overflow <= 1'b1;
    end
  end

  // Full stays asserted unless a word is retired
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (full && !popReq) |=> full);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= depthReg);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && full) |=> overflow);

  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (empty && popReq && !accept) |=> empty);

  assert_push_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && popReq && !full && !empty) |=> (count == $past(count)));
endmodule

// File: rtl/lbd_datapath.sv
module lbd_datapath
  import lbd_pkg::*;
#(
  parameter int DATA_W  = 54,
  parameter int RING_AW = 8,
  parameter int FIFO_AW = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  lbd_strobe_t        strobes,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic [RING_AW-1:0] rdInit,
  input  logic [RING_AW-1:0] wrInit,
  output logic [DATA_W-1:0]  rdData
);
  localparam int RING_DEPTH = 1 << RING_AW;
  localparam int FIFO_MAX   = 1 << FIFO_AW;

  logic [DATA_W-1:0]  ringMem [RING_DEPTH];
  logic [DATA_W-1:0]  fifoMem [FIFO_MAX];
  logic [RING_AW-1:0] ringWr;
  logic [RING_AW-1:0] ringRd;
  logic [FIFO_AW-1:0] fifoWr;
  logic [FIFO_AW-1:0] fifoRd;
  logic [DATA_W-1:0]  ringOut;

  // The read happens before this edge's write, so a zero pointer gap yields a full-turn latency
  assign ringOut = ringMem[ringRd];
  assign rdData  = fifoMem[fifoRd];

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      ringWr <= wrInit;
      ringRd <= rdInit;
    end else begin
      ringWr <= ringWr + 1'b1;
      ringRd <= ringRd + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!strobes.load) ringMem[ringWr] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (strobes.push) fifoMem[fifoWr] <= ringOut;
  end

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      fifoWr <= '0;
      fifoRd <= '0;
    end else begin
      if (strobes.push) fifoWr <= fifoWr + 1'b1;
      if (strobes.pop)  fifoRd <= fifoRd + 1'b1;
    end
  end

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (ringRd == $past(ringRd) + 1'b1));

  assert_latency_const_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((ringWr - ringRd) == $past(ringWr - ringRd)));

  assert_fifo_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> (fifoRd == $past(fifoRd) + 1'b1));
endmodule

// File: rtl/latency_derand.sv
module latency_derand
  import lbd_pkg::*;
#(
  parameter int DATA_W  = 54,
  parameter int RING_AW = 8,
  parameter int FIFO_AW = 7,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               accept,
  input  logic               popReq,
  input  logic [RING_AW-1:0] rdInit,
  input  logic [RING_AW-1:0] wrInit,
  input  logic [SEL_W-1:0]   depthSel,
  output logic [DATA_W-1:0]  rdData,
  output logic               empty,
  output logic               full,
  output logic               overflow
);
  lbd_strobe_t strobes;

  lbd_control #(.FIFO_AW(FIFO_AW), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .accept(accept), .popReq(popReq),
    .depthSel(depthSel), .strobes(strobes), .empty(empty),
    .full(full), .overflow(overflow)
  );

  lbd_datapath #(.DATA_W(DATA_W), .RING_AW(RING_AW), .FIFO_AW(FIFO_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .rdInit(rdInit), .wrInit(wrInit), .rdData(rdData)
  );
endmodule

// File: tb/tb_latency_derand.sv
module tb_latency_derand;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [53:0] dataIn = '0;
  logic        accept = 1'b0;
  logic        popReq = 1'b0;
  logic [7:0]  rdInit = '0;
  logic [7:0]  wrInit = '0;
  logic [1:0]  depthSel = '0;
  logic [53:0] rdData;
  logic        empty, full, overflow;

  int testsRun = 0;
  int testsFail = 0;
  int k = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  latency_derand dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .accept(accept), .popReq(popReq),
    .rdInit(rdInit), .wrInit(wrInit), .depthSel(depthSel),
    .rdData(rdData), .empty(empty), .full(full), .overflow(overflow)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] rd;
    logic [7:0] wr;
    logic [7:0] n;
    logic       expFull;
    logic       expOvf;
  } row_t;

  localparam int NROWS = 5;
  localparam row_t ROWS [NROWS] = '{
    '{2'd0, 8'd0,   8'd10,  8'd5,   1'b0, 1'b0},
    '{2'd0, 8'd250, 8'd4,   8'd16,  1'b1, 1'b0},
    '{2'd1, 8'd100, 8'd103, 8'd33,  1'b1, 1'b1},
    '{2'd2, 8'd7,   8'd7,   8'd64,  1'b1, 1'b0},
    '{2'd3, 8'd0,   8'd1,   8'd130, 1'b1, 1'b1}
  };

  function automatic logic [53:0] pat(int idx);
    logic [31:0] u;
    u = 32'(idx);
    return {u[21:0] ^ 22'h2A5A5, u * 32'h9E3779B1};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    dataIn = pat(k);
    @(posedge clk);
    k++;
    @(negedge clk);
  endtask

  task automatic doReset(logic [1:0] s, logic [7:0] r, logic [7:0] w);
    rstN = 1'b0; accept = 1'b0; popReq = 1'b0;
    depthSel = s; rdInit = r; wrInit = w;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    k = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Drain m words that must equal pat(first..first+m-1), then expect empty
  task automatic drain(int first, int m, string req);
    for (int j = 0; j < m; j++) begin
      check(!empty, req, 64'(empty), 64'd0);
      check(rdData == pat(first + j), req, 64'(rdData), 64'(pat(first + j)));
      popReq = 1'b1; step(); popReq = 1'b0;
    end
    check(empty, req, 64'(empty), 64'd1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      testsRun++; testsFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);

    // R1 / R9: reset state
    doReset(2'd0, 8'd0, 8'd3);
    check(empty == 1'b1, "R1 empty after reset", 64'(empty), 64'd1);
    check(full == 1'b0, "R1 full after reset", 64'(full), 64'd0);
    check(overflow == 1'b0, "R1 overflow after reset", 64'(overflow), 64'd0);
    check(empty == 1'b1, "R9 no words", 64'(empty), 64'd1);

    // Table rows: R2 latency incl. wrap and zero gap, R4 depths, R3 overflow, R5 order
    for (int r = 0; r < NROWS; r++) begin
      automatic int lat = int'(8'(ROWS[r].wr - ROWS[r].rd));
      automatic int dep = 16 << ROWS[r].sel;
      automatic int n = int'(ROWS[r].n);
      automatic int m = (n < dep) ? n : dep;
      if (lat == 0) lat = 256;
      doReset(ROWS[r].sel, ROWS[r].rd, ROWS[r].wr);
      idle(lat);
      for (int i = 0; i < n; i++) begin
        accept = 1'b1; step();
      end
      accept = 1'b0;
      check(full == ROWS[r].expFull, "R4 full vs selected depth", 64'(full), 64'(ROWS[r].expFull));
      check(overflow == ROWS[r].expOvf, "R3 overflow on dropped accept", 64'(overflow), 64'(ROWS[r].expOvf));
      drain(0, m, "R2 R5 latency and order");
      check(overflow == ROWS[r].expOvf, "R3 overflow sticky after drain", 64'(overflow), 64'(ROWS[r].expOvf));
    end

    // R8: configuration changes after reset are ignored
    doReset(2'd0, 8'd0, 8'd5);
    depthSel = 2'd3; rdInit = 8'd0; wrInit = 8'd100;
    idle(5);
    for (int i = 0; i < 17; i++) begin
      accept = 1'b1; step();
    end
    accept = 1'b0;
    check(full == 1'b1, "R8 depth unchanged", 64'(full), 64'd1);
    check(overflow == 1'b1, "R8 seventeenth accept dropped", 64'(overflow), 64'd1);
    drain(0, 16, "R8 latency unchanged");

    // R6: pops on empty are ignored
    doReset(2'd1, 8'd0, 8'd2);
    for (int i = 0; i < 3; i++) begin
      popReq = 1'b1; step();
    end
    popReq = 1'b0;
    check(empty == 1'b1, "R6 still empty", 64'(empty), 64'd1);
    check(overflow == 1'b0, "R6 no overflow", 64'(overflow), 64'd0);
    idle(2);
    accept = 1'b1; step(); accept = 1'b0;
    drain(3, 1, "R6 single word intact");

    // R7: simultaneous accept and pop
    doReset(2'd0, 8'd0, 8'd4);
    idle(4);
    for (int i = 0; i < 3; i++) begin
      accept = 1'b1; step();
    end
    accept = 1'b1; popReq = 1'b1; step();
    accept = 1'b0; popReq = 1'b0;
    drain(1, 3, "R7 count kept and order");

    // R3: accept with pop while full is dropped
    doReset(2'd0, 8'd0, 8'd4);
    idle(4);
    for (int i = 0; i < 16; i++) begin
      accept = 1'b1; step();
    end
    check(full == 1'b1, "R4 full at 16", 64'(full), 64'd1);
    accept = 1'b1; popReq = 1'b1; step();
    accept = 1'b0; popReq = 1'b0;
    check(full == 1'b0, "R3 drop at full with pop", 64'(full), 64'd0);
    check(overflow == 1'b1, "R3 overflow set", 64'(overflow), 64'd1);
    check(rdData == pat(1), "R3 R5 next oldest word", 64'(rdData), 64'(pat(1)));
    idle(10);
    check(overflow == 1'b1, "R3 overflow holds", 64'(overflow), 64'd1);
    drain(1, 15, "R3 remaining words");
    doReset(2'd0, 8'd0, 8'd4);
    check(overflow == 1'b0, "R1 reset clears overflow", 64'(overflow), 64'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule